// File: doc/BRIEF.md
# Rectangle Fill Engine

This block fills an axis-aligned rectangle in a pixel-addressed frame buffer. Software programs it through a small write-only register port. The registers hold a control word, the foreground and background colours, two words of 8x8 monochrome pattern, the horizontal span, the clip window and the line pitch. Writing the vertical-run register is the last step of setup, and that write starts the fill. No separate "go" command exists.

Each pixel gets a source value. The source is either the foreground colour, or the pattern bit for that pixel expanded to the foreground or background colour. A 4-bit raster operation then merges the source with the destination pixel. The destination is read from memory only when the chosen operation depends on it. Pixels outside the clip window cause no memory traffic at all. The engine walks the rectangle line by line, from left to right. It issues one request at a time to a simple synchronous memory port with an acknowledge handshake.

While a fill runs, the engine reports busy and holds off further register writes through a ready signal. A running fill therefore always sees the setup it was started with.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy` is 0, `reg_ready` is 1 and `mem_req` is 0.
- R2: A write to register index 10 (vertical run) starts a fill only if the control register (index 0) holds opcode 4 in bits 3:0. With any other opcode, the write starts nothing and causes no memory access.
- R3: Register index 5 holds the first column (inclusive) in bits 15:0 and the end column (exclusive) in bits 31:16. Register index 10 holds the first line in bits 31:16 and the line count in bits 15:0. Pixels are visited line by line, left to right, at address line*pitch + column, where the pitch is register index 9. A count of 0, or an end column not greater than the first column, gives no memory access.
- R4: When control bit 11 is 1, or control bit 29 is 0, every source pixel equals the foreground colour (register index 1).
- R5: When control bit 29 is 1 and bit 11 is 0, the source comes from the pattern, which is anchored to frame-buffer coordinates. The pattern row is line mod 8 and the pattern column is column mod 8. Rows 0-3 sit in register index 3 and rows 4-7 in index 4, one byte per row, with the lowest row in the least significant byte. Bit 7 of a row byte is column 0. A 1 bit selects the foreground colour and a 0 bit selects the background colour (index 2).
- R6: Control bits 19:16 select the raster operation. The codes are: 0x0 all zeros, 0x1 NOT(src OR dst), 0x3 NOT src, 0x6 src XOR dst, 0x8 src AND dst, 0xC src, 0xE src OR dst, 0xF all ones.
- R7: For operations 0x0, 0x3, 0xC and 0xF, pixels are written without any read. For every other operation, each pixel is first read and then written at the same address.
- R8: Register index 6 holds the clip left column in bits 15:0 and the clip right column in bits 31:16, both inclusive. Register indices 7 and 8 hold the top and bottom limits, both inclusive, compared against line*pitch. Pixels outside the window are neither read nor written. A fill that lies wholly outside the window makes no memory access.
- R9: `busy` is 1 from the cycle after the triggering write until the last pixel write is acknowledged. While it is 1, `reg_ready` is 0 and register writes are held off, so the running fill uses the values it started with.
- R10: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`. After an acknowledged read, the engine waits for `mem_rvalid` and uses `mem_rdata` as the destination value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write request |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Register write accepted this cycle when high |
| busy | output | 1 | Fill in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Pixel address |
| mem_wdata | output | PIX_W | Pixel write data |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rdata | input | PIX_W | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The first fill is a solid rectangle. It pins down address order and the exclusive end column. The next is a pattern fill more than eight lines tall and eight columns wide, starting at odd coordinates. It shows whether the pattern is anchored to the frame buffer and whether the byte and bit order of the pattern words is right. A sweep of all eight raster operations over a non-uniform destination tells the operations apart, and the read count shows which ones read before writing. Clip windows that cut a fill in part or miss it entirely, non-fill opcodes, empty spans, randomly stalled acknowledges, and a register write attempted mid-fill cover the remaining behaviour.

// File: rtl/rf_pkg.sv
// Shared constants and types for the rectangle fill engine.
// Assumes a 32-bit register write port and 16-bit pixel coordinates.
package rf_pkg;
    localparam int CRD_W = 16;

    localparam logic [3:0] RI_CTRL  = 4'd0;
    localparam logic [3:0] RI_FG    = 4'd1;
    localparam logic [3:0] RI_BG    = 4'd2;
    localparam logic [3:0] RI_PATLO = 4'd3;
    localparam logic [3:0] RI_PATHI = 4'd4;
    localparam logic [3:0] RI_SPAN  = 4'd5;
    localparam logic [3:0] RI_CLIPX = 4'd6;
    localparam logic [3:0] RI_CTOP  = 4'd7;
    localparam logic [3:0] RI_CBOT  = 4'd8;
    localparam logic [3:0] RI_PITCH = 4'd9;
    localparam logic [3:0] RI_YRUN  = 4'd10;

    localparam logic [3:0] OPC_FILL  = 4'h4;
    localparam int         SOLID_BIT = 11;
    localparam int         PAT_BIT   = 29;
    localparam int         ROP_LSB   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_READ,
        ST_WAITRD,
        ST_WRITE
    } seq_state_t;
endpackage

// File: rtl/rf_regs.sv
// Setup register file for the fill engine.
// Captures accepted writes. A write to the vertical-run register while the
// stored opcode is the fill opcode raises a one-cycle start pulse that is
// seen in the following cycle. Assumes wr_en is already qualified by ready.
module rf_regs
    import rf_pkg::*;
#(
    parameter int PIX_W  = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              start_q,
    output logic              use_solid,
    output logic              use_pat,
    output logic [3:0]        rop,
    output logic [PIX_W-1:0]  fg,
    output logic [PIX_W-1:0]  bg,
    output logic [31:0]       pat_lo,
    output logic [31:0]       pat_hi,
    output logic [CRD_W-1:0]  span_l,
    output logic [CRD_W-1:0]  span_r,
    output logic [CRD_W-1:0]  clip_l,
    output logic [CRD_W-1:0]  clip_r,
    output logic [ADDR_W-1:0] clip_top,
    output logic [ADDR_W-1:0] clip_bot,
    output logic [CRD_W-1:0]  pitch,
    output logic [CRD_W-1:0]  y_start,
    output logic [CRD_W-1:0]  y_count
);
    logic [3:0] opcode;

    // Register capture and start pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            opcode    <= '0;
            use_solid <= 1'b0;
            use_pat   <= 1'b0;
            rop       <= '0;
            fg        <= '0;
            bg        <= '0;
            pat_lo    <= '0;
            pat_hi    <= '0;
            span_l    <= '0;
            span_r    <= '0;
            clip_l    <= '0;
            clip_r    <= '1;
            clip_top  <= '0;
            clip_bot  <= '1;
            pitch     <= '0;
            y_start   <= '0;
            y_count   <= '0;
        end else begin
            start_q <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    RI_CTRL: begin
                        opcode    <= wr_data[3:0];
                        use_solid <= wr_data[SOLID_BIT];
                        use_pat   <= wr_data[PAT_BIT];
                        rop       <= wr_data[ROP_LSB +: 4];
                    end
                    RI_FG:    fg       <= wr_data[PIX_W-1:0];
                    RI_BG:    bg       <= wr_data[PIX_W-1:0];
                    RI_PATLO: pat_lo   <= wr_data;
                    RI_PATHI: pat_hi   <= wr_data;
                    RI_SPAN: begin
                        span_l <= wr_data[CRD_W-1:0];
                        span_r <= wr_data[2*CRD_W-1:CRD_W];
                    end
                    RI_CLIPX: begin
                        clip_l <= wr_data[CRD_W-1:0];
                        clip_r <= wr_data[2*CRD_W-1:CRD_W];
                    end
                    RI_CTOP:  clip_top <= wr_data[ADDR_W-1:0];
                    RI_CBOT:  clip_bot <= wr_data[ADDR_W-1:0];
                    RI_PITCH: pitch    <= wr_data[CRD_W-1:0];
                    RI_YRUN: begin
                        y_count <= wr_data[CRD_W-1:0];
                        y_start <= wr_data[2*CRD_W-1:CRD_W];
                        start_q <= (opcode == OPC_FILL);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rf_shade.sv
// Per-pixel colour path: chooses the source (solid foreground or expanded
// pattern bit) and merges it with the destination through the raster
// operation. Purely combinational. Also reports whether the operation
// reads the destination.
module rf_shade #(
    parameter int PIX_W = 32
) (
    input  logic             use_solid,
    input  logic             use_pat,
    input  logic [3:0]       rop,
    input  logic [PIX_W-1:0] fg,
    input  logic [PIX_W-1:0] bg,
    input  logic [31:0]      pat_lo,
    input  logic [31:0]      pat_hi,
    input  logic [2:0]       pat_col,
    input  logic [2:0]       pat_row,
    input  logic [PIX_W-1:0] dst,
    output logic [PIX_W-1:0] px_out,
    output logic             needs_dst
);
    logic [31:0]      row_word;
    logic [7:0]       row_byte;
    logic             pat_bit;
    logic [PIX_W-1:0] src;

    // Select the pattern bit for this pixel and form the source colour
    always_comb begin
        row_word = pat_row[2] ? pat_hi : pat_lo;
        row_byte = row_word[{pat_row[1:0], 3'b000} +: 8];
        pat_bit  = row_byte[3'd7 - pat_col];
        src      = (use_pat && !use_solid && !pat_bit) ? bg : fg;
    end

    // Bitwise raster operation: truth table indexed by {src, dst}
    for (genvar i = 0; i < PIX_W; i++) begin : g_rop
        assign px_out[i] = rop[{src[i], dst[i]}];
    end

    // Destination matters when the table differs across dst values
    assign needs_dst = (rop[3] ^ rop[2]) | (rop[1] ^ rop[0]);
endmodule

// File: rtl/rf_seq.sv
// Rectangle walker and memory sequencer. Loads the span on start, steps
// through pixels in raster order, skips pixels outside the clip window and
// issues read-then-write or write-only requests. One request is
// outstanding at a time. Assumes setup registers stay unchanged while busy.
module rf_seq
    import rf_pkg::*;
#(
    parameter int PIX_W  = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CRD_W-1:0]  span_l,
    input  logic [CRD_W-1:0]  span_r,
    input  logic [CRD_W-1:0]  clip_l,
    input  logic [CRD_W-1:0]  clip_r,
    input  logic [ADDR_W-1:0] clip_top,
    input  logic [ADDR_W-1:0] clip_bot,
    input  logic [CRD_W-1:0]  pitch,
    input  logic [CRD_W-1:0]  y_start,
    input  logic [CRD_W-1:0]  y_count,
    input  logic              needs_dst,
    input  logic [PIX_W-1:0]  shade_px,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    output logic [2:0]        pat_col,
    output logic [2:0]        pat_row,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata
);
    seq_state_t          state;
    logic [CRD_W-1:0]    cur_x;
    logic [2:0]          y_low;
    logic [CRD_W-1:0]    lines;
    logic [ADDR_W-1:0]   row_base;
    logic [PIX_W-1:0]    wdata_q;
    logic [2*CRD_W-1:0]  start_base;
    logic                span_empty, in_clip, col_end, run_end, step, direct_wr;

    // Geometry decisions for the current pixel
    always_comb begin
        start_base = {{CRD_W{1'b0}}, y_start} * {{CRD_W{1'b0}}, pitch};
        span_empty = (lines == '0) || (span_r <= span_l);
        in_clip    = (cur_x >= clip_l) && (cur_x <= clip_r) &&
                     (row_base >= clip_top) && (row_base <= clip_bot);
        col_end    = ({1'b0, cur_x} + 1'b1) == {1'b0, span_r};
        run_end    = col_end && (lines == 1);
        step       = ((state == ST_SCAN) && !span_empty && !in_clip) ||
                     ((state == ST_WRITE) && mem_ack);
        direct_wr  = (state == ST_SCAN) && !span_empty && in_clip && !needs_dst;
    end

    // Pixel position, line base address and remaining line count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x    <= '0;
            y_low    <= '0;
            lines    <= '0;
            row_base <= '0;
        end else if ((state == ST_IDLE) && start) begin
            cur_x    <= span_l;
            y_low    <= y_start[2:0];
            lines    <= y_count;
            row_base <= start_base[ADDR_W-1:0];
        end else if (step) begin
            if (col_end) begin
                cur_x    <= span_l;
                y_low    <= y_low + 3'd1;
                lines    <= lines - 1'b1;
                row_base <= row_base + ADDR_W'(pitch);
            end else begin
                cur_x <= cur_x + 1'b1;
            end
        end
    end

    // Sequencer state transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_SCAN;
                ST_SCAN: begin
                    if (span_empty)      state <= ST_IDLE;
                    else if (in_clip)    state <= needs_dst ? ST_READ : ST_WRITE;
                    else if (run_end)    state <= ST_IDLE;
                end
                ST_READ:   if (mem_ack) state <= ST_WAITRD;
                ST_WAITRD: if (mem_rvalid) state <= ST_WRITE;
                ST_WRITE:  if (mem_ack) state <= run_end ? ST_IDLE : ST_SCAN;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Latch the pixel value to be written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (direct_wr || ((state == ST_WAITRD) && mem_rvalid)) begin
            wdata_q <= shade_px;
        end
    end

    assign pat_col   = cur_x[2:0];
    assign pat_row   = y_low;
    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = row_base + ADDR_W'(cur_x);
    assign mem_wdata = wdata_q;
endmodule

// File: rtl/rect_fill_engine.sv
// Top of the rectangle fill engine. Joins the register file, the colour
// path and the walker. Register writes are accepted only while idle; the
// cycle after a triggering write already counts as busy.
module rect_fill_engine #(
    parameter int PIX_W  = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ready,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_rvalid
);
    import rf_pkg::*;

    logic              start_q, use_solid, use_pat, needs_dst, seq_busy;
    logic [3:0]        rop;
    logic [PIX_W-1:0]  fg, bg, shade_px;
    logic [31:0]       pat_lo, pat_hi;
    logic [CRD_W-1:0]  span_l, span_r, clip_l, clip_r, pitch, y_start, y_count;
    logic [ADDR_W-1:0] clip_top, clip_bot;
    logic [2:0]        pat_col, pat_row;

    assign busy      = seq_busy | start_q;
    assign reg_ready = !busy;

    rf_regs #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en && reg_ready), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .start_q(start_q), .use_solid(use_solid), .use_pat(use_pat), .rop(rop),
        .fg(fg), .bg(bg), .pat_lo(pat_lo), .pat_hi(pat_hi),
        .span_l(span_l), .span_r(span_r), .clip_l(clip_l), .clip_r(clip_r),
        .clip_top(clip_top), .clip_bot(clip_bot), .pitch(pitch),
        .y_start(y_start), .y_count(y_count)
    );

    rf_shade #(.PIX_W(PIX_W)) u_shade (
        .use_solid(use_solid), .use_pat(use_pat), .rop(rop),
        .fg(fg), .bg(bg), .pat_lo(pat_lo), .pat_hi(pat_hi),
        .pat_col(pat_col), .pat_row(pat_row), .dst(mem_rdata),
        .px_out(shade_px), .needs_dst(needs_dst)
    );

    rf_seq #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_q),
        .span_l(span_l), .span_r(span_r), .clip_l(clip_l), .clip_r(clip_r),
        .clip_top(clip_top), .clip_bot(clip_bot), .pitch(pitch),
        .y_start(y_start), .y_count(y_count),
        .needs_dst(needs_dst), .shade_px(shade_px),
        .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
        .pat_col(pat_col), .pat_row(pat_row), .busy(seq_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/rf_fill_checker.sv
// Protocol checks on the fill engine ports, bound to the top module.
module rf_fill_checker #(
    parameter int PIX_W  = 32,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [3:0]        reg_addr,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PIX_W-1:0]  mem_wdata,
    input logic              mem_ack
);
    // R1/R9: no memory traffic unless a fill is running
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R10: an unaccepted request is held unchanged
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R10: an accepted read is followed by a wait for data, not a new request
    a_r10_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> !mem_req);

    // R9: busy rises only right after a write to the vertical-run register
    a_r9_busy_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr_en && (reg_addr == 4'd10)));

    // R9: busy ends only after a write is accepted or with no pending request
    a_r9_busy_ends_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!mem_req || (mem_we && mem_ack)));
endmodule

bind rect_fill_engine rf_fill_checker #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_fill_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/rect_fill_engine_bench.sv
// Scoreboard bench: fill tasks push expected writes into a queue, the
// memory monitor pops and compares every accepted write.
module rect_fill_engine_bench;
    localparam int PW = 32;
    localparam int AW = 24;
    localparam int PITCH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_ready, busy, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [PW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [PW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0;

    always #5 clk = ~clk;

    rect_fill_engine #(.PIX_W(PW), .ADDR_W(AW)) u_rect_fill_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid)
    );

    logic [31:0] fbmem [0:1023];
    logic [31:0] gold  [0:1023];
    logic [63:0] expq[$];
    int n_checks = 0, n_fail = 0, n_wr = 0, n_rd = 0, exp_rd = 0, cyc = 0;
    logic [7:0]  lfsr = 8'hA5;
    logic        rd_pend = 1'b0;
    logic [9:0]  rd_addr = '0;

    // shadow setup
    logic [31:0] sh_ctrl = 0, sh_fg = 0, sh_bg = 0, sh_plo = 0, sh_phi = 0;
    logic [31:0] sh_cl = 0, sh_cr = 32'hFFFF, sh_ct = 0, sh_cb = 32'hFFFFFF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Memory model and monitor: acknowledges, returns read data, scores writes
    always @(negedge clk) begin
        if (rd_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = fbmem[rd_addr];
            rd_pend    = 1'b0;
        end else begin
            mem_rvalid = 1'b0;
        end
        lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ack = rst_n && (lfsr[0] | lfsr[2]);
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                n_wr++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write addr", 32'(mem_addr), 32'hFFFFFFFF);
                end else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    chk(32'(mem_addr) == e[63:32], "R3", "write address", 32'(mem_addr), e[63:32]);
                    chk(mem_wdata == e[31:0], "R6", "write data", mem_wdata, e[31:0]);
                end
                fbmem[mem_addr[9:0]] = mem_wdata;
            end else begin
                n_rd++;
                rd_pend = 1'b1;
                rd_addr = mem_addr[9:0];
                if (expq.size() != 0)
                    chk(32'(mem_addr) == expq[0][63:32], "R7", "read address",
                        32'(mem_addr), expq[0][63:32]);
                else
                    chk(1'b0, "R7", "unexpected read", 32'(mem_addr), 32'hFFFFFFFF);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<100000", cyc);
            report();
            $finish;
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        while (!reg_ready) @(negedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (a)
            4'd0: sh_ctrl = d;
            4'd1: sh_fg = d;
            4'd2: sh_bg = d;
            4'd3: sh_plo = d;
            4'd4: sh_phi = d;
            4'd6: begin sh_cl = {16'b0, d[15:0]}; sh_cr = {16'b0, d[31:16]}; end
            4'd7: sh_ct = d;
            4'd8: sh_cb = d;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] apply_rop(input logic [3:0] r, input logic [31:0] s,
                                              input logic [31:0] d);
        case (r)
            4'h0: return 32'h0;
            4'h1: return ~(s | d);
            4'h3: return ~s;
            4'h6: return s ^ d;
            4'h8: return s & d;
            4'hC: return s;
            4'hE: return s | d;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic logic [31:0] src_of(input int x, input int y);
        logic [31:0] w;
        logic [7:0]  b;
        if (sh_ctrl[11] || !sh_ctrl[29]) return sh_fg;
        w = ((y % 8) < 4) ? sh_plo : sh_phi;
        b = w[((y % 4) * 8) +: 8];
        return b[7 - (x % 8)] ? sh_fg : sh_bg;
    endfunction

    // Push expectations for a fill, then trigger it
    task automatic fill_start(input int x, input int w, input int y, input int h);
        logic [3:0] r;
        r = sh_ctrl[19:16];
        reg_write(4'd5, 32'(((x + w) << 16) | x));
        if (sh_ctrl[3:0] == 4'h4) begin
            for (int yy = y; yy < y + h; yy++) begin
                for (int xx = x; xx < x + w; xx++) begin
                    int a;
                    a = yy * PITCH + xx;
                    if (xx >= int'(sh_cl) && xx <= int'(sh_cr) &&
                        a - xx >= int'(sh_ct) && a - xx <= int'(sh_cb)) begin
                        if (!(r == 4'h0 || r == 4'h3 || r == 4'hC || r == 4'hF)) exp_rd++;
                        gold[a] = apply_rop(r, src_of(xx, yy), gold[a]);
                        expq.push_back({32'(a), gold[a]});
                    end
                end
            end
        end
        reg_write(4'd10, 32'((y << 16) | h));
    endtask

    task automatic fill_end(input string req);
        while (busy) @(negedge clk);
        chk(expq.size() == 0, req, "writes outstanding after fill", 32'(expq.size()), 0);
        chk(n_rd == exp_rd, "R7", "read count", 32'(n_rd), 32'(exp_rd));
    endtask

    task automatic fill(input int x, input int w, input int y, input int h, input string req);
        fill_start(x, w, y, h);
        fill_end(req);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            fbmem[i] = (i * 32'h01030507) ^ 32'h5A5A3C3C;
            gold[i]  = fbmem[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        chk(reg_ready == 1'b1, "R1", "ready after reset", 32'(reg_ready), 1);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);

        reg_write(4'd9, PITCH);

        // R4 R3: solid copy, exclusive end column
        reg_write(4'd0, 32'h4 | (32'h1 << 11) | (32'hC << 16));
        reg_write(4'd1, 32'h11223344);
        reg_write(4'd2, 32'hDEADBEEF);
        reg_write(4'd3, 32'hF03C0FA5);
        reg_write(4'd4, 32'h55AA817E);
        fill(2, 4, 1, 3, "R4");

        // R5: pattern copy spanning more than 8 lines and columns, odd origin
        reg_write(4'd0, 32'h4 | (32'h1 << 29) | (32'hC << 16));
        fill(5, 10, 3, 9, "R5");

        // R4: solid bit overrides pattern enable
        reg_write(4'd0, 32'h4 | (32'h1 << 29) | (32'h1 << 11) | (32'hC << 16));
        fill(16, 3, 2, 2, "R4");

        // R6 R7: every raster operation with pattern source over varied data
        reg_write(4'd1, 32'hC3C30F0F);
        reg_write(4'd2, 32'h5A5AF00F);
        for (int k = 0; k < 8; k++) begin
            logic [3:0] ops [8];
            ops = '{4'h0, 4'h1, 4'h3, 4'h6, 4'h8, 4'hC, 4'hE, 4'hF};
            reg_write(4'd0, 32'h4 | (32'h1 << 29) | (32'(ops[k]) << 16));
            fill(20, 5, k * 2, 2, "R6");
        end

        // R8: partial clip
        reg_write(4'd0, 32'h4 | (32'h1 << 11) | (32'h6 << 16));
        reg_write(4'd6, (32'd6 << 16) | 32'd4);
        reg_write(4'd7, 2 * PITCH);
        reg_write(4'd8, 3 * PITCH);
        fill(0, 11, 0, 6, "R8");

        // R8: fill wholly outside clip makes no access
        begin
            int w0, r0;
            w0 = n_wr; r0 = n_rd;
            fill(20, 3, 10, 2, "R8");
            chk(n_wr == w0 && n_rd == r0, "R8", "accesses outside clip",
                32'(n_wr - w0 + n_rd - r0), 0);
        end
        reg_write(4'd6, 32'hFFFF0000);
        reg_write(4'd7, 0);
        reg_write(4'd8, 32'hFFFFFF);

        // R2: non-fill opcode does not start
        begin
            int w0;
            w0 = n_wr;
            reg_write(4'd0, 32'h5 | (32'h1 << 11) | (32'hC << 16));
            fill_start(1, 3, 28, 2);
            chk(busy == 1'b0, "R2", "busy with non-fill opcode", 32'(busy), 0);
            repeat (5) @(negedge clk);
            chk(n_wr == w0, "R2", "writes with non-fill opcode", 32'(n_wr - w0), 0);
        end

        // R3: empty spans
        begin
            int w0;
            w0 = n_wr;
            reg_write(4'd0, 32'h4 | (32'h1 << 11) | (32'hC << 16));
            fill(3, 4, 25, 0, "R3");
            fill(3, 0, 25, 3, "R3");
            chk(n_wr == w0, "R3", "writes for empty span", 32'(n_wr - w0), 0);
        end

        // R9 R10: register write held off while busy, fill keeps old colour
        reg_write(4'd1, 32'hAAAA5555);
        fill_start(0, 8, 20, 4);
        @(negedge clk);
        chk(reg_ready == 1'b0, "R9", "ready while busy", 32'(reg_ready), 0);
        reg_write(4'd1, 32'h0BADF00D);
        chk(busy == 1'b0, "R9", "write accepted only after fill", 32'(busy), 0);
        chk(expq.size() == 0, "R9", "fill finished with old colour", 32'(expq.size()), 0);
        fill(10, 2, 28, 1, "R10");

        report();
        $finish;
    end
endmodule